// File: doc/BRIEF.md
# Configuration Bitstream Streamer

This block feeds stored configuration bytes to a programmable logic device. On the storage side it puts out a read address and takes the byte at that address back in the same cycle. On the device side it drives the byte either one bit at a time on data pin 0 (narrow mode) or as a whole byte on pins 0 to 7 (wide mode). A per-pin output enable marks which pins are driven. Each rising edge of `clk` on which streaming is allowed moves the stream forward by one bit or one byte.

Several streamers can be chained. When a streamer has sent its last byte, it releases its data pins and pulls its chain-enable output low. That output is wired to the chip enable of the next streamer. An output enable input, active high, doubles as a restart: holding it low rewinds the stream. While the storage is being reprogrammed, the data pins float and the chain-enable output is held high. When reprogramming ends, the block produces a short low pulse on its restart-pull output. That pulse also rewinds the stream.

Top module: `cfgs_stream`

## Requirements
- R1: `cfg_dq_oe` is 8'h00 unless `chip_en_n` is 0, `out_en_rst_n` is 1 and `cfg_go` is 1. While any of these three conditions is not met, the stream position (`rd_addr` and bit index) does not change.
- R2: In wide mode (`wide_mode`=1), with streaming enabled, `cfg_dq_oe` is 8'hFF and `cfg_dq` equals `rd_data`. Each rising edge with `busy`=0 moves `rd_addr` on by one.
- R3: In wide mode, a rising edge with `busy`=1 leaves `rd_addr` and the presented byte unchanged.
- R4: In narrow mode (`wide_mode`=0), `cfg_dq_oe` is 8'h01. `cfg_dq[0]` carries bit k of `rd_data` on the k-th enabled edge for that address, counting from k=0. Bit 0 goes first. After bit 7, `rd_addr` moves on by one. `busy` has no effect in this mode.
- R5: The last byte is at address LAST_ADDR. Once it has been fully sent (one edge in wide mode, eight edges in narrow mode), `next_en_n` goes low and `cfg_dq_oe` becomes 8'h00. Both stay so until the stream is rewound.
- R6: A rising edge with `out_en_rst_n`=0 sets `rd_addr` to 0, sets the bit index to 0 and sets `next_en_n` high. While `out_en_rst_n` is 0, `cfg_dq_oe` is 8'h00.
- R7: While `prog_active` is 1, `next_en_n` is 1, `cfg_dq_oe` is 8'h00 and the stream position does not change.
- R8: On the first rising edge after `prog_active` falls, `rst_pull_n` goes low. It stays low for PULSE_LEN cycles and then returns high. After the pulse, the stream restarts at address 0, bit 0, with `next_en_n` high.
- R9: Synchronous `rst` sets `rd_addr` to 0, sets `next_en_n` high and sets `rst_pull_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the stream advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_rst_n | input | 1 | Output enable when high; rewinds the stream when low |
| cfg_go | input | 1 | Must be high for data to be driven |
| busy | input | 1 | Stall request from the device (wide mode only) |
| wide_mode | input | 1 | 1 = byte-wide output, 0 = one bit on pin 0 |
| prog_active | input | 1 | Storage reprogramming in progress |
| rd_addr | output | ADDR_W | Read address to the storage |
| rd_data | input | 8 | Byte stored at `rd_addr` (same cycle) |
| cfg_dq | output | 8 | Data pin values |
| cfg_dq_oe | output | 8 | Per-pin drive enable (1 = driven) |
| next_en_n | output | 1 | Chain enable for the next device, low after the last byte |
| rst_pull_n | output | 1 | Low pulse on the restart line after reprogramming |

## Verification
A wrong position counter appears on `rd_addr` at the very next edge. It shows up as a skipped or repeated address, or as an address that moves while `busy` is high. A wrong bit index shows on `cfg_dq[0]` within one narrow-mode edge, because every bit is compared against the byte the bench stores at that address. A done flag that is set too early or cleared too late changes `next_en_n` and `cfg_dq_oe` one edge away from the expected cycle. The bench therefore checks both signals on the cycle before the final edge and on the cycle after it. Errors in the restart pulse appear as a wrong low count on `rst_pull_n` or as a stream that does not resume at address 0.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic sel;      // chip enable asserted
        logic oe;       // output enable high
        logic go;       // configuration request high
        logic prog;     // reprogramming in progress
        logic rewind;   // pulse in flight
    } gate_t;

    function automatic logic [BYTE_W-1:0] lane_mask(input lane_mode_e m);
        return (m == MODE_WIDE) ? {BYTE_W{1'b1}} : BYTE_W'(1);
    endfunction

    function automatic logic may_stream(input gate_t g);
        return g.sel && g.oe && g.go && !g.prog && !g.rewind;
    endfunction

endpackage

// File: rtl/cfgs_addr_seq.sv
module cfgs_addr_seq
    import cfgs_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LAST_ADDR = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step_ok,
    input  logic                 busy,
    input  lane_mode_e           mode,
    output logic [ADDR_W-1:0]    addr,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 done
);

    localparam logic [ADDR_W-1:0]    ADDR_END = ADDR_W'(LAST_ADDR);
    localparam logic [BIT_IDX_W-1:0] BIT_END  = BIT_IDX_W'(BYTE_W - 1);

    logic advance;
    logic byte_end;

    always_comb begin
        advance  = step_ok && !done && ((mode == MODE_NARROW) || !busy);
        byte_end = (mode == MODE_WIDE) || (bit_idx == BIT_END);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr    <= '0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else if (advance) begin
            if (byte_end) begin
                bit_idx <= '0;
                if (addr == ADDR_END) begin
                    done <= 1'b1;
                end else begin
                    addr <= addr + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgs_prog_exit.sv
module cfgs_prog_exit #(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_active,
    output logic pulse_on,
    output logic rst_pull_n
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic             prog_q;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= 1'b0;
            remain <= '0;
        end else begin
            prog_q <= prog_active;
            if (prog_q && !prog_active) begin
                remain <= CNT_W'(PULSE_LEN);
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    always_comb begin
        pulse_on   = (remain != '0);
        rst_pull_n = !pulse_on;
    end

endmodule

// File: rtl/cfgs_pin_drv.sv
module cfgs_pin_drv
    import cfgs_pkg::*;
(
    input  logic                 drive,
    input  lane_mode_e           mode,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    output logic [BYTE_W-1:0]    dq,
    output logic [BYTE_W-1:0]    dq_oe
);

    always_comb begin
        dq_oe = drive ? lane_mask(mode) : '0;
        if (!drive) begin
            dq = '0;
        end else if (mode == MODE_WIDE) begin
            dq = byte_in;
        end else begin
            dq = BYTE_W'(byte_in[bit_idx]);
        end
    end

endmodule

// File: rtl/cfgs_stream.sv
module cfgs_stream
    import cfgs_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int PULSE_LEN = 3,
    parameter int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en_n,
    input  logic              out_en_rst_n,
    input  logic              cfg_go,
    input  logic              busy,
    input  logic              wide_mode,
    input  logic              prog_active,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [7:0]        cfg_dq,
    output logic [7:0]        cfg_dq_oe,
    output logic              next_en_n,
    output logic              rst_pull_n
);

    localparam int LAST_ADDR = DEPTH - 1;

    gate_t                 gate;
    lane_mode_e            mode;
    logic                  pulse_on;
    logic                  step_ok;
    logic                  clr;
    logic                  done;
    logic [BIT_IDX_W-1:0]  bit_idx;

    always_comb begin
        mode        = lane_mode_e'(wide_mode);
        gate.sel    = !chip_en_n;
        gate.oe     = out_en_rst_n;
        gate.go     = cfg_go;
        gate.prog   = prog_active;
        gate.rewind = pulse_on;
        step_ok     = may_stream(gate);
        clr         = !out_en_rst_n || pulse_on;
        next_en_n   = prog_active || !done;
    end

    cfgs_prog_exit #(.PULSE_LEN(PULSE_LEN)) u_exit (
        .clk         (clk),
        .rst         (rst),
        .prog_active (prog_active),
        .pulse_on    (pulse_on),
        .rst_pull_n  (rst_pull_n)
    );

    cfgs_addr_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step_ok (step_ok),
        .busy    (busy),
        .mode    (mode),
        .addr    (rd_addr),
        .bit_idx (bit_idx),
        .done    (done)
    );

    cfgs_pin_drv u_pins (
        .drive   (step_ok && !done),
        .mode    (mode),
        .byte_in (rd_data),
        .bit_idx (bit_idx),
        .dq      (cfg_dq),
        .dq_oe   (cfg_dq_oe)
    );

endmodule

// File: rtl/cfgs_stream_chk.sv
module cfgs_stream_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en_n,
    input logic              out_en_rst_n,
    input logic              cfg_go,
    input logic              busy,
    input logic              wide_mode,
    input logic              prog_active,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        cfg_dq_oe,
    input logic              next_en_n,
    input logic              rst_pull_n
);

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_en_n || !out_en_rst_n || !cfg_go) |-> (cfg_dq_oe == 8'h00));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && busy && out_en_rst_n && rst_pull_n) |=> $stable(rd_addr));

    // R4
    narrow_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> ((cfg_dq_oe & 8'hFE) == 8'h00));

    // R5
    chain_float_chk: assert property (@(posedge clk) disable iff (rst)
        !next_en_n |-> (cfg_dq_oe == 8'h00));

    // R6
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en_rst_n |=> (rd_addr == '0));

    // R7
    prog_float_chk: assert property (@(posedge clk) disable iff (rst)
        prog_active |-> (next_en_n && cfg_dq_oe == 8'h00));

    // R8
    exit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!prog_active && $past(prog_active)) |=> !rst_pull_n);

endmodule

bind cfgs_stream cfgs_stream_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chip_en_n    (chip_en_n),
    .out_en_rst_n (out_en_rst_n),
    .cfg_go       (cfg_go),
    .busy         (busy),
    .wide_mode    (wide_mode),
    .prog_active  (prog_active),
    .rd_addr      (rd_addr),
    .cfg_dq_oe    (cfg_dq_oe),
    .next_en_n    (next_en_n),
    .rst_pull_n   (rst_pull_n)
);

// File: tb/test_cfgs_stream.sv
`timescale 1ns/1ps
module test_cfgs_stream;

    localparam int DEPTH  = 12;
    localparam int PLEN   = 3;
    localparam int ADDR_W = 4;

    // {busy, expected address before the edge}
    localparam logic [4:0] VEC [15] = '{
        5'b0_0000, 5'b0_0001, 5'b1_0010, 5'b1_0010, 5'b0_0010,
        5'b0_0011, 5'b1_0100, 5'b0_0100, 5'b0_0101, 5'b0_0110,
        5'b0_0111, 5'b0_1000, 5'b0_1001, 5'b0_1010, 5'b0_1011
    };

    logic clk = 1'b0;
    logic rst, chip_en_n, out_en_rst_n, cfg_go, busy, wide_mode, prog_active;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0] rd_data, cfg_dq, cfg_dq_oe;
    logic next_en_n, rst_pull_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return 8'(int'(a) * 29 + 91);
    endfunction

    always_comb rd_data = pat(rd_addr);

    cfgs_stream #(.DEPTH(DEPTH), .PULSE_LEN(PLEN)) i_cfgs_stream (
        .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_rst_n(out_en_rst_n),
        .cfg_go(cfg_go), .busy(busy), .wide_mode(wide_mode), .prog_active(prog_active),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_dq(cfg_dq), .cfg_dq_oe(cfg_dq_oe),
        .next_en_n(next_en_n), .rst_pull_n(rst_pull_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1; chip_en_n = 1; out_en_rst_n = 1; cfg_go = 0;
        busy = 0; wide_mode = 1; prog_active = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        eq("R9 addr", rd_addr, 0);
        eq("R9 chain", next_en_n, 1);
        eq("R9 pull", rst_pull_n, 1);
        eq("R1 oe with chip off", cfg_dq_oe, 0);

        // wide stream walked through the vector table
        chip_en_n = 0; cfg_go = 1;
        for (int i = 0; i < 15; i++) begin
            busy = VEC[i][4];
            #1;
            eq("R2/R3 addr", rd_addr, int'(VEC[i][3:0]));
            eq("R2 byte", cfg_dq, pat(VEC[i][3:0]));
            eq("R2 oe", cfg_dq_oe, 8'hFF);
            eq("R5 chain before end", next_en_n, 1);
            @(negedge clk);
        end
        busy = 0;
        #1;
        eq("R5 chain low", next_en_n, 0);
        eq("R5 float", cfg_dq_oe, 0);
        @(negedge clk); @(negedge clk);
        #1;
        eq("R5 chain stays low", next_en_n, 0);

        // rewind by output enable
        out_en_rst_n = 0;
        #1;
        eq("R6 float", cfg_dq_oe, 0);
        @(negedge clk);
        out_en_rst_n = 1;
        #1;
        eq("R6 addr", rd_addr, 0);
        eq("R6 chain", next_en_n, 1);

        // gating holds position
        cfg_go = 0;
        #1;
        eq("R1 oe go low", cfg_dq_oe, 0);
        @(negedge clk);
        #1;
        eq("R1 hold go low", rd_addr, 0);
        cfg_go = 1; chip_en_n = 1;
        #1;
        eq("R1 oe chip off", cfg_dq_oe, 0);
        @(negedge clk);
        #1;
        eq("R1 hold chip off", rd_addr, 0);
        chip_en_n = 0;
        @(negedge clk);
        #1;
        eq("R2 step after gate", rd_addr, 1);

        // narrow stream, busy toggled and ignored
        out_en_rst_n = 0;
        @(negedge clk);
        out_en_rst_n = 1; wide_mode = 0;
        for (int w = 0; w < DEPTH; w++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] ref_byte;
                ref_byte = pat(ADDR_W'(w));
                busy = b[0];
                #1;
                eq("R4 addr", rd_addr, w);
                eq("R4 bit", cfg_dq[0], ref_byte[b]);
                eq("R4 oe", cfg_dq_oe, 8'h01);
                eq("R5 chain before end", next_en_n, 1);
                @(negedge clk);
            end
        end
        busy = 0;
        #1;
        eq("R5 narrow chain low", next_en_n, 0);
        eq("R5 narrow float", cfg_dq_oe, 0);

        // reprogramming and exit pulse
        prog_active = 1;
        #1;
        eq("R7 chain high", next_en_n, 1);
        eq("R7 float", cfg_dq_oe, 0);
        @(negedge clk); @(negedge clk);
        #1;
        eq("R7 still high", next_en_n, 1);
        prog_active = 0;
        #1;
        eq("R8 not yet", rst_pull_n, 1);
        for (int k = 0; k < PLEN; k++) begin
            @(negedge clk);
            #1;
            eq("R8 pulse low", rst_pull_n, 0);
        end
        @(negedge clk);
        #1;
        eq("R8 pulse end", rst_pull_n, 1);
        eq("R8 addr", rd_addr, 0);
        eq("R8 chain", next_en_n, 1);
        eq("R8 restart oe", cfg_dq_oe, 8'h01);

        // synchronous reset mid-stream
        wide_mode = 1;
        repeat (3) @(negedge clk);
        #1;
        eq("R2 advance", rd_addr, 3);
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        eq("R9 mid addr", rd_addr, 0);
        eq("R9 mid chain", next_en_n, 1);

        finish_run();
    end

endmodule